// File: doc/BRIEF.md
# Serial-Memory Erase Command Slave

This block is the device side of a three-wire serial memory link, reduced to the two erase commands and the ready/busy report that follows them. A host drives chip select, a serial clock and a serial data line. The block brings all three into a fast system clock domain, decodes a command frame and then runs a self-timed erase against a small internal word array. The erase starts when chip select falls after the last address bit. It needs no further serial clock pulses to finish.

When the host raises chip select again after a long enough low time, the block drives its data-out line with the erase status: 0 while the erase is still running and 1 once it has finished. At all other times data-out is released. The line is modelled as a value plus an output enable, and the pad's tri-state buffer sits outside the block. Every array write shows up on a write strobe, and a combinational peek port reads any word back, so the array contents can be checked from outside.

Top module: `mw_erase_slave`

## Requirements
- R1: After reset the data-out enable is 0, no write strobe is issued, and every array word reads 0 through the peek port.
- R2: A frame is a 1 start bit, then a 2-bit opcode, then ADDR_W address bits, all sent MSB first. Data-in is sampled on rising serial-clock edges while chip select is high. Zero bits before the start bit are skipped.
- R3: Opcode 11 writes all-ones to the addressed word with exactly one write strobe. No other word changes.
- R4: Opcode 00 with the top two address bits equal to 10 writes all-ones to every word. It issues one strobe per word in ascending order from address 0, and the lower address bits are ignored.
- R5: The erase starts only on a chip-select fall that follows a complete frame. A fall before the last address bit starts nothing.
- R6: The busy period lasts ERASE_CYCLES system clocks, or DEPTH if that is larger. It finishes with no serial clock activity, and write strobes occur only while busy.
- R7: Chip select may be raised after an erase has started, having been low for at least CSL_CYCLES clocks. Data-out is then enabled and reads 0 while busy and 1 when ready. If chip select was low for less than that, data-out stays disabled.
- R8: Data-out is disabled while chip select is low and while a frame is being loaded.
- R9: With erase-enable low at the chip-select fall, the frame is dropped: there is no strobe and data-out stays disabled.
- R10: Frames sent while an erase is busy are ignored.
- R11: Opcodes 01 and 10, and opcode 00 without the 10 tag, are dropped with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| erase_en_i | input | 1 | Erase permission, synchronous |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Data-out enable (0 = high impedance) |
| mem_we_o | output | 1 | Array write strobe |
| mem_waddr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| peek_addr_i | input | ADDR_W | Array read-back address |
| peek_data_o | output | DATA_W | Array read-back data |

## Verification
The assertions assume that erase-enable is steady around each chip-select fall. They also assume the serial pins change slowly enough, compared with the system clock, that the synchronisers see every level, so that each serial-clock high and low phase spans several system clocks. The bench drives every serial level for four system clocks and changes erase-enable only while chip select is high in the middle of a frame. It ties the status checks to chip-select low times chosen well clear of the minimum, at 4 and 20 clocks against a minimum of 13.

// File: rtl/mw_pkg.sv
// Package: shared encodings for the serial erase slave.
// Assumes a 2-bit opcode field directly after the start bit.
package mw_pkg;
    localparam logic [1:0] OPC_ERASE   = 2'b11;
    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] TAG_ERALL   = 2'b10;

    typedef enum logic [1:0] {
        FR_IDLE = 2'b00,
        FR_LOAD = 2'b01,
        FR_FULL = 2'b10
    } fr_state_t;
endpackage

// File: rtl/mw_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherence is needed.
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // capture the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= async_i;
                end
            end else begin : g_next
                // pass down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/mw_frame.sv
// Module: frame loader. Waits for a start bit, shifts in opcode and
// address MSB first on serial-clock rises, and holds the frame in FULL.
// Assumes the inputs are already synchronised; chip select low clears it.
module mw_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_rise,
    input  logic              di_s,
    input  logic              block,
    output logic              start_pulse,
    output logic              frame_full,
    output logic              loading,
    output logic [1:0]        opcode,
    output logic [ADDR_W-1:0] addr
);
    localparam int FRAME_W = ADDR_W + 2;
    localparam int CW      = $clog2(FRAME_W + 1);

    fr_state_t          state;
    logic [CW-1:0]      cnt;
    logic [FRAME_W-1:0] sr;

    // start bit accepted this cycle
    assign start_pulse = cs_s && sclk_rise && (state == FR_IDLE) && !block && di_s;

    // frame state machine and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
            sr    <= '0;
        end else if (!cs_s) begin
            state <= FR_IDLE;
            cnt   <= '0;
        end else if (sclk_rise) begin
            case (state)
                FR_IDLE: begin
                    if (start_pulse) begin
                        state <= FR_LOAD;
                        cnt   <= '0;
                    end
                end
                FR_LOAD: begin
                    sr  <= {sr[FRAME_W-2:0], di_s};
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(FRAME_W - 1)) state <= FR_FULL;
                end
                default: ;
            endcase
        end
    end

    assign frame_full = (state == FR_FULL);
    assign loading    = (state == FR_LOAD);
    assign opcode     = sr[FRAME_W-1 -: 2];
    assign addr       = sr[ADDR_W-1:0];
endmodule

// File: rtl/mw_erase_engine.sv
// Module: self-timed erase sequencer. One strobe for a single word, or
// one strobe per word from address 0 for a full erase; busy for RUN clocks.
// Assumes start is only honoured while idle.
module mw_erase_engine #(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_all,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int RUN   = (ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH;
    localparam int TW    = $clog2(RUN + 1);

    logic [TW-1:0]   timer;
    logic [ADDR_W:0] pend;

    // busy timer and write walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            timer <= '0;
            pend  <= '0;
            waddr <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                timer <= TW'(RUN - 1);
                pend  <= start_all ? (ADDR_W+1)'(DEPTH) : (ADDR_W+1)'(1);
                waddr <= start_all ? '0 : start_addr;
            end
        end else begin
            if (pend != '0) begin
                pend  <= pend - 1'b1;
                waddr <= waddr + 1'b1;
            end
            if (timer == '0) busy  <= 1'b0;
            else             timer <= timer - 1'b1;
        end
    end

    assign we    = busy && (pend != '0);
    assign wdata = '1;
endmodule

// File: rtl/mw_status.sv
// Module: ready/busy reporter. Arms on an erase start, disarms on the next
// start bit, and drives data-out while chip select is high after a long
// enough low phase. Assumes edge pulses derived from the synced select.
module mw_status #(
    parameter int CSL_CYCLES = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic cs_rise,
    input  logic cs_fall,
    input  logic arm_set,
    input  logic arm_clr,
    input  logic busy,
    output logic show,
    output logic do_val
);
    localparam int LW = $clog2(CSL_CYCLES + 1);

    logic [LW-1:0] low_cnt;
    logic          armed;

    // measure chip-select low time, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_cnt <= '0;
        else if (cs_s)                       low_cnt <= '0;
        else if (low_cnt != LW'(CSL_CYCLES)) low_cnt <= low_cnt + 1'b1;
    end

    // remember that an erase was launched
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (arm_set) armed <= 1'b1;
        else if (arm_clr) armed <= 1'b0;
    end

    // enable data-out for a qualified status check
    always_ff @(posedge clk) begin
        if (!rst_n)       show <= 1'b0;
        else if (cs_fall) show <= 1'b0;
        else if (cs_rise && armed && (low_cnt == LW'(CSL_CYCLES))) show <= 1'b1;
    end

    assign do_val = show && !busy;
endmodule

// File: rtl/mw_regfile.sv
// Module: word array with one write port and a combinational peek port.
// Assumes all words clear to zero on reset.
module mw_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // clear on reset, write on strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_erase_slave.sv
// Module: top of the serial erase slave. Synchronises the serial pins,
// loads frames, decodes erase commands at the chip-select fall and
// reports status on data-out. Assumes erase_en_i is synchronous to clk.
module mw_erase_slave
    import mw_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 200,
    parameter int CSL_CYCLES   = 13,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              di_i,
    input  logic              erase_en_i,
    output logic              do_o,
    output logic              do_oe_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_waddr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o
);
    logic [2:0]        pins_s;
    logic              cs_s, sclk_s, di_s;
    logic              cs_d, sclk_d;
    logic              cs_fall, cs_rise, sclk_rise;
    logic              busy, show, start_pulse, frame_full, loading;
    logic [1:0]        opcode;
    logic [ADDR_W-1:0] f_addr;
    logic              is_one, is_all, go_erase;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({cs_i, sclk_i, di_i}), .sync_o(pins_s)
    );
    assign {cs_s, sclk_s, di_s} = pins_s;

    // delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d && !cs_s;
    assign cs_rise   = !cs_d && cs_s;
    assign sclk_rise = !sclk_d && sclk_s;

    mw_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_rise(sclk_rise),
        .di_s(di_s), .block(busy || show), .start_pulse(start_pulse),
        .frame_full(frame_full), .loading(loading), .opcode(opcode),
        .addr(f_addr)
    );

    // command decode at the chip-select fall
    assign is_one   = (opcode == OPC_ERASE);
    assign is_all   = (opcode == OPC_SPECIAL) && (f_addr[ADDR_W-1 -: 2] == TAG_ERALL);
    assign go_erase = cs_fall && frame_full && erase_en_i && !busy && (is_one || is_all);

    mw_erase_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(go_erase), .start_all(is_all),
        .start_addr(f_addr), .busy(busy), .we(mem_we_o),
        .waddr(mem_waddr_o), .wdata(mem_wdata_o)
    );

    mw_status #(.CSL_CYCLES(CSL_CYCLES)) u_status (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise),
        .cs_fall(cs_fall), .arm_set(go_erase), .arm_clr(start_pulse),
        .busy(busy), .show(show), .do_val(do_o)
    );
    assign do_oe_o = show;

    mw_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we_o), .waddr(mem_waddr_o),
        .wdata(mem_wdata_o), .raddr(peek_addr_i), .rdata(peek_data_o)
    );
endmodule

// File: rtl/mw_erase_slave_chk.sv
// Module: property checker for the serial erase slave, bound to the top.
// Assumes erase_en is steady around each chip-select fall.
module mw_erase_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              cs_d,
    input logic              busy,
    input logic              loading,
    input logic              frame_full,
    input logic              erase_en,
    input logic              do_o,
    input logic              do_oe,
    input logic              we,
    input logic [DATA_W-1:0] wdata
);
    // R8: released while select has been low for two cycles
    p_hiz_cs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !cs_d) |-> !do_oe);

    // R8: released while a frame is loading
    p_hiz_loading_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> !do_oe);

    // R7: busy reads 0
    p_busy_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && busy) |-> !do_o);

    // R7: ready reads 1
    p_ready_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && !busy) |-> do_o);

    // R6: strobes only inside the busy period
    p_strobe_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> busy);

    // R3: erase data is all ones
    p_wdata_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (&wdata));

    // R5: busy begins right after a select fall
    p_start_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_d) && !$past(cs_s)));

    // R9: no erase without permission
    p_enable_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(erase_en));

    // R10: no frame accumulates while busy
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!frame_full && !loading));
endmodule

bind mw_erase_slave mw_erase_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_d(cs_d), .busy(busy),
    .loading(loading), .frame_full(frame_full), .erase_en(erase_en_i),
    .do_o(do_o), .do_oe(do_oe_o), .we(mem_we_o), .wdata(mem_wdata_o)
);

// File: tb/mw_erase_slave_test.sv
// Bench: scoreboard of expected array writes plus direct status checks.
module mw_erase_slave_test;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int ERASE  = 200;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_i = 1'b0, sclk_i = 1'b0, di_i = 1'b0;
    logic              erase_en_i = 1'b1;
    logic              do_o, do_oe_o, mem_we_o;
    logic [ADDR_W-1:0] mem_waddr_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic [ADDR_W-1:0] peek_addr_i = '0;
    logic [DATA_W-1:0] peek_data_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic [ADDR_W-1:0] exp_q [$];

    always #10 clk = ~clk;

    mw_erase_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE),
                     .CSL_CYCLES(13), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_i(sclk_i), .di_i(di_i),
        .erase_en_i(erase_en_i), .do_o(do_o), .do_oe_o(do_oe_o),
        .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o),
        .mem_wdata_o(mem_wdata_o), .peek_addr_i(peek_addr_i),
        .peek_data_o(peek_data_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di_i = b;   clks(4);
        sclk_i = 1; clks(4);
        sclk_i = 0;
    endtask

    // drop select briefly, raise it, then clock leading zeros and a frame
    task automatic send_frame(input int lead, input logic [1:0] op,
                              input logic [ADDR_W-1:0] a, input int nbits);
        cs_i = 0; clks(4);
        cs_i = 1; clks(4);
        for (int i = 0; i < lead; i++) send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = ADDR_W - 1; i >= ADDR_W - nbits; i--) send_bit(a[i]);
    endtask

    task automatic cs_low(input int n);
        cs_i = 0; clks(n);
        cs_i = 1; clks(6);
    endtask

    task automatic peek(input string req, input logic [ADDR_W-1:0] a,
                        input int exp);
        peek_addr_i = a; #1;
        chk(req, int'(peek_data_o), exp);
    endtask

    // monitor: compare each strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3/R4 strobe: got addr %0h expected none", mem_waddr_o);
            end else begin
                logic [ADDR_W-1:0] e;
                e = exp_q.pop_front();
                if (mem_waddr_o != e || mem_wdata_o != '1) begin
                    fails++;
                    $display("FAIL R3/R4 strobe: got %0h/%0h expected %0h/ff",
                             mem_waddr_o, mem_wdata_o, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        clks(150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        clks(4); rst_n = 1; clks(2);
        // R1 reset state
        chk("R1 oe", int'(do_oe_o), 0);
        chk("R1 we", int'(mem_we_o), 0);
        peek("R1 word0", 7'h00, 0);
        peek("R1 word7f", 7'h7f, 0);

        // R2 R3 single erase with leading zeros
        exp_q.push_back(7'h25);
        send_frame(3, 2'b11, 7'h25, ADDR_W);
        chk("R8 loaded", int'(do_oe_o), 0);
        cs_i = 0; clks(3);
        chk("R8 cs low", int'(do_oe_o), 0);
        clks(17); cs_i = 1; clks(6);
        chk("R7 busy oe", int'(do_oe_o), 1);
        chk("R7 busy val", int'(do_o), 0);
        clks(ERASE - 60);
        chk("R6 still busy", int'(do_o), 0);
        clks(60);
        chk("R6 R7 ready", int'(do_o), 1);
        chk("R7 ready oe", int'(do_oe_o), 1);
        peek("R3 target", 7'h25, 8'hff);
        peek("R3 neighbour", 7'h24, 0);
        peek("R3 neighbour2", 7'h26, 0);

        // R7 short low, R10 frame during busy
        exp_q.push_back(7'h10);
        send_frame(0, 2'b11, 7'h10, ADDR_W);
        cs_low(4);
        chk("R7 short low", int'(do_oe_o), 0);
        send_frame(0, 2'b11, 7'h11, ADDR_W);
        cs_i = 0; clks(ERASE + 20); cs_i = 1; clks(4);
        peek("R10 ignored", 7'h11, 0);
        peek("R3 second", 7'h10, 8'hff);

        // R9 erase disabled
        send_frame(0, 2'b11, 7'h30, 4);
        erase_en_i = 0;
        send_frame(0, 2'b11, 7'h30, 0);
        for (int i = ADDR_W - 1; i >= 0; i--) send_bit(i[0] ? 1'b0 : 1'b0);
        cs_low(20);
        erase_en_i = 1;
        chk("R9 oe", int'(do_oe_o), 0);
        clks(ERASE + 10);
        peek("R9 word", 7'h00, 0);

        // R11 bad opcodes
        send_frame(0, 2'b01, 7'h40, ADDR_W);
        cs_low(20);
        chk("R11 op01 oe", int'(do_oe_o), 0);
        send_frame(0, 2'b10, 7'h41, ADDR_W);
        cs_low(20);
        send_frame(0, 2'b00, 7'h7f, ADDR_W);
        cs_low(20);
        chk("R11 op00 oe", int'(do_oe_o), 0);
        clks(ERASE + 10);
        peek("R11 word40", 7'h40, 0);
        peek("R11 word41", 7'h41, 0);

        // R5 truncated frame
        send_frame(0, 2'b11, 7'h50, 3);
        cs_low(20);
        chk("R5 oe", int'(do_oe_o), 0);
        clks(ERASE + 10);
        peek("R5 word", 7'h50, 0);

        // R4 erase all, low bits arbitrary
        for (int i = 0; i < DEPTH; i++) exp_q.push_back(ADDR_W'(i));
        send_frame(2, 2'b00, 7'b1010110, ADDR_W);
        cs_i = 0; clks(20); cs_i = 1; clks(6);
        chk("R4 busy", int'(do_o), 0);
        clks(ERASE + 10);
        chk("R4 ready", int'(do_o), 1);
        peek("R4 word0", 7'h00, 8'hff);
        peek("R4 word5a", 7'h5a, 8'hff);
        peek("R4 word7f", 7'h7f, 8'hff);
        chk("R4 all strobes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule